// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block turns three parallel framebuffer planes into one stream of 24-bit RGB pixels. Each input beat carries, for one pixel position, an 8-bit palette index, a 32-bit word from the true-colour plane and a 32-bit word from the control plane. The top byte of the control word decides the pixel's source. With one tag value the colour comes straight from the true-colour word, and its padding byte is discarded. With any other tag value the colour is looked up in an external palette through a synchronous read port.

Every plane has a fixed line stride of `STRIDE` pixels. The programmed active width may be shorter than the stride, and pixels past it are consumed and dropped. Line and row counters produce an end-of-line flag and a start-of-frame flag on the output. Both sides use a valid/ready handshake and move one pixel per cycle. A single pipeline stage gives the palette time to answer. A per-pixel swap input can exchange the red and blue channels.

Top module: `pixel_source_mux`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. The first pixel accepted after reset is column 0 of row 0.
- R2: A pixel whose control word has bits [31:24] equal to 8'h03 outputs bits [23:0] of its true-colour word. Bits [31:24] of that word have no effect. Colour order on every 24-bit bus is red [23:16], green [15:8], blue [7:0].
- R3: Any other tag value makes the pixel output the palette entry at its index. The block drives `pal_rd_en` with `pal_addr` = `s_index` in the cycle the pixel is accepted. It expects `pal_rd_data` on the following cycle.
- R4: When `cfg_swap_rb` is 1 at the accepting edge, that pixel's output has bits [23:16] and [7:0] exchanged.
- R5: Every line consumes exactly `STRIDE` accepted input beats. Beats at columns at or beyond `cfg_width` (1..STRIDE) produce no output beat.
- R6: `m_last` is 1 exactly on the output beat for column `cfg_width`-1.
- R7: `m_frame_start` is 1 exactly on the output beat for column 0 of row 0. Rows wrap to 0 after `cfg_height` lines.
- R8: While `m_valid` is 1 and `m_ready` is 0, the output beat (`m_valid`, `m_data`, `m_last`, `m_frame_start`) stays unchanged.
- R9: An accepted active pixel appears on the output on the next cycle. `s_ready` is 1 whenever the output stage is empty or being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(STRIDE+1) | Active pixels per line, 1..STRIDE |
| cfg_height | input | $clog2(MAX_LINES+1) | Lines per frame, 1..MAX_LINES |
| cfg_swap_rb | input | 1 | Exchange red and blue on this pixel |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_index | input | 8 | Palette index from the 8-bit plane |
| s_direct | input | 32 | True-colour plane word |
| s_ctrl | input | 32 | Control plane word, tag in [31:24] |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette entry, one cycle after the strobe |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 24 | Output RGB pixel |
| m_last | output | 1 | Last active pixel of the line |
| m_frame_start | output | 1 | First pixel of the frame |

## Verification
The assertions check the following on every cycle:
- a direct-tagged active pixel emerges one cycle later with its low 24 bits, swapped when the swap input was set;
- palette reads happen only for accepted pixels whose tag is not direct;
- skipped columns never create an output beat;
- a stalled output beat holds still;
- the input is never blocked while the stage is empty.

Other behaviour can only be shown by the bench's scenarios, which change the width and height between frames. This covers the column and row bookkeeping: which beat carries the line-end and frame-start flags, and the exact number of beats per line and per frame. It also covers palette data captured during long stalls, and corner tags such as 0x02 and 0x83 that must not count as direct.

// File: rtl/pixel_source_mux.sv
module pixel_source_mux #(
  parameter int          STRIDE    = 1024,
  parameter int          MAX_LINES = 768,
  parameter logic [7:0]  DIRECT_TAG = 8'h03,
  localparam int         COL_W = $clog2(STRIDE),
  localparam int         WID_W = $clog2(STRIDE + 1),
  localparam int         HGT_W = $clog2(MAX_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WID_W-1:0] cfg_width,
  input  logic [HGT_W-1:0] cfg_height,
  input  logic             cfg_swap_rb,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_index,
  input  logic [31:0]      s_direct,
  input  logic [31:0]      s_ctrl,
  output logic             pal_rd_en,
  output logic [7:0]       pal_addr,
  input  logic [23:0]      pal_rd_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [23:0]      m_data,
  output logic             m_last,
  output logic             m_frame_start
);

  logic [COL_W-1:0] col;
  logic [HGT_W-1:0] row;

  logic        stg_valid, stg_direct, stg_swap, stg_last, stg_first, stg_fresh;
  logic [23:0] stg_rgb, pal_hold, colour;

  logic accept, is_direct, pix_active, line_end, frame_end;

  assign accept     = s_valid && s_ready;
  assign s_ready    = !stg_valid || m_ready;
  assign is_direct  = s_ctrl[31:24] == DIRECT_TAG;
  assign pix_active = WID_W'(col) < cfg_width;
  assign line_end   = col == COL_W'(STRIDE - 1);
  assign frame_end  = row >= cfg_height - HGT_W'(1);

  assign pal_rd_en  = accept && pix_active && !is_direct;
  assign pal_addr   = s_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (accept) begin
      if (line_end) begin
        col <= '0;
        row <= frame_end ? '0 : row + HGT_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_valid  <= 1'b0;
      stg_direct <= 1'b0;
      stg_swap   <= 1'b0;
      stg_last   <= 1'b0;
      stg_first  <= 1'b0;
      stg_fresh  <= 1'b0;
      stg_rgb    <= '0;
      pal_hold   <= '0;
    end else begin
      if (stg_fresh) pal_hold <= pal_rd_data;
      stg_fresh <= accept && pix_active && !is_direct;
      if (accept && pix_active) begin
        stg_valid  <= 1'b1;
        stg_direct <= is_direct;
        stg_swap   <= cfg_swap_rb;
        stg_rgb    <= s_direct[23:0];
        stg_last   <= WID_W'(col) == cfg_width - WID_W'(1);
        stg_first  <= col == '0 && row == '0;
      end else if (m_ready) begin
        stg_valid  <= 1'b0;
      end
    end
  end

  assign colour = stg_direct ? stg_rgb : (stg_fresh ? pal_rd_data : pal_hold);

  assign m_valid       = stg_valid;
  assign m_data        = stg_swap ? {colour[7:0], colour[15:8], colour[23:16]} : colour;
  assign m_last        = stg_valid && stg_last;
  assign m_frame_start = stg_valid && stg_first;

endmodule

// File: rtl/pixel_source_mux_chk.sv
module pixel_source_mux_chk #(
  parameter logic [7:0] DIRECT_TAG = 8'h03
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic [31:0] s_direct,
  input logic [31:0] s_ctrl,
  input logic        cfg_swap_rb,
  input logic        pix_active,
  input logic        pal_rd_en,
  input logic        m_valid,
  input logic        m_ready,
  input logic [23:0] m_data,
  input logic        m_last,
  input logic        m_frame_start
);

  p_direct_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && pix_active && s_ctrl[31:24] == DIRECT_TAG |=>
      m_valid && m_data == ($past(cfg_swap_rb)
        ? {$past(s_direct[7:0]), $past(s_direct[15:8]), $past(s_direct[23:16])}
        : $past(s_direct[23:0])));

  p_pal_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |-> s_valid && s_ready && s_ctrl[31:24] != DIRECT_TAG);

  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !pix_active |=> !m_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last)
                            && $stable(m_frame_start));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_last || m_frame_start) |-> m_valid);

endmodule

bind pixel_source_mux pixel_source_mux_chk #(.DIRECT_TAG(DIRECT_TAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_direct(s_direct), .s_ctrl(s_ctrl), .cfg_swap_rb(cfg_swap_rb),
  .pix_active(pix_active), .pal_rd_en(pal_rd_en), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .m_frame_start(m_frame_start)
);

// File: tb/tb_pixel_source_mux.sv
`timescale 1ns/1ps
module tb_pixel_source_mux;
  localparam int STRIDE = 16;
  localparam int LINES  = 8;
  localparam int WID_W  = $clog2(STRIDE + 1);
  localparam int HGT_W  = $clog2(LINES + 1);

  logic clk = 0, rst_n = 0;
  logic [WID_W-1:0] cfg_width = WID_W'(STRIDE);
  logic [HGT_W-1:0] cfg_height = HGT_W'(2);
  logic cfg_swap_rb = 0, s_valid = 0, m_ready = 0;
  logic s_ready, pal_rd_en, m_valid, m_last, m_frame_start;
  logic [7:0]  s_index = 0, pal_addr;
  logic [31:0] s_direct = 0, s_ctrl = 0;
  logic [23:0] pal_rd_data, m_data;
  logic [23:0] pal_mem [256];

  int errors = 0, checks = 0;
  int bx = 0, by = 0;
  int dir_i = 0;
  logic [27:0] expq[$];
  logic prev_stall = 0;
  logic [25:0] prev_beat = 0;

  always #5 clk = ~clk;

  pixel_source_mux #(.STRIDE(STRIDE), .MAX_LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_swap_rb(cfg_swap_rb), .s_valid(s_valid), .s_ready(s_ready),
    .s_index(s_index), .s_direct(s_direct), .s_ctrl(s_ctrl),
    .pal_rd_en(pal_rd_en), .pal_addr(pal_addr), .pal_rd_data(pal_rd_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .m_frame_start(m_frame_start));

  always_ff @(posedge clk) if (pal_rd_en) pal_rd_data <= pal_mem[pal_addr];

  function automatic logic [23:0] exp_colour(logic [31:0] c, logic [31:0] d,
                                             logic [7:0] i, logic sw);
    logic [23:0] v;
    v = (c[31:24] == 8'h03) ? d[23:0] : pal_mem[i];
    return sw ? {v[7:0], v[15:8], v[23:16]} : v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic new_pixel();
    logic [31:0] dc [5];
    dc[0] = 32'h0300_0000; dc[1] = 32'h03FF_FFFF; dc[2] = 32'h02FF_FFFF;
    dc[3] = 32'h8300_0000; dc[4] = 32'hFF12_3456;
    s_index  = 8'($urandom);
    s_direct = $urandom;
    if (dir_i < 5) begin
      s_ctrl = dc[dir_i];
      s_direct[31:24] = 8'hAB;
      dir_i++;
    end else begin
      s_ctrl = ($urandom % 2) ? {8'h03, 24'($urandom)} : $urandom;
    end
    cfg_swap_rb = 1'($urandom);
  endtask

  task automatic observe();
    logic [27:0] e;
    if (prev_stall)
      check(m_valid && {m_frame_start, m_last, m_data} == prev_beat, "R8",
            {6'd0, m_frame_start, m_last, m_data}, {6'd0, prev_beat});
    if (!m_valid) check(s_ready, "R9", 32'(s_ready), 1);
    if (m_valid && m_ready) begin
      if (expq.size() == 0) begin
        check(0, "R5 extra beat", 32'(m_data), 0);
      end else begin
        e = expq.pop_front();
        check(m_data == e[23:0], e[27] ? (e[26] ? "R2/R4" : "R2") : (e[26] ? "R3/R4" : "R3"),
              32'(m_data), 32'(e[23:0]));
        check(m_last == e[24], "R6", 32'(m_last), 32'(e[24]));
        check(m_frame_start == e[25], "R7", 32'(m_frame_start), 32'(e[25]));
      end
    end
    prev_stall = m_valid && !m_ready;
    prev_beat  = {m_frame_start, m_last, m_data};
    if (s_valid && s_ready) begin
      if (bx < int'(cfg_width))
        expq.push_back({s_ctrl[31:24] == 8'h03, cfg_swap_rb, bx == 0 && by == 0,
                        bx == int'(cfg_width) - 1,
                        exp_colour(s_ctrl, s_direct, s_index, cfg_swap_rb)});
      if (bx == STRIDE - 1) begin
        bx = 0;
        by = (by == int'(cfg_height) - 1) ? 0 : by + 1;
      end else bx++;
    end
  endtask

  task automatic run(int w, int h, int frames, int vp, int rp);
    int total, sent, outs, exp_outs;
    logic took;
    cfg_width = WID_W'(w); cfg_height = HGT_W'(h);
    total = frames * h * STRIDE; sent = 0; outs = 0; took = 1;
    exp_outs = frames * h * w;
    while (sent < total || expq.size() != 0 || m_valid) begin
      @(negedge clk);
      if (took) s_valid = 0;
      if (!s_valid && sent < total && ($urandom % 100) < vp) begin
        s_valid = 1; new_pixel();
      end
      m_ready = ($urandom % 100) < rp;
      #1;
      took = s_valid && s_ready;
      if (took) sent++;
      if (m_valid && m_ready) outs++;
      observe();
    end
    @(negedge clk); s_valid = 0;
    check(outs == exp_outs, "R5", 32'(outs), 32'(exp_outs));
    check(bx == 0 && by == 0, "R7 frame wrap", 32'(by), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 256; i++) pal_mem[i] = 24'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!m_valid, "R1", 32'(m_valid), 0);
    check(s_ready, "R1", 32'(s_ready), 1);
    run(STRIDE, 3, 2, 100, 100);
    run(5, 4, 2, 80, 50);
    run(1, 2, 1, 70, 30);
    run(STRIDE, LINES, 1, 60, 20);
    run(9, 5, 2, 90, 90);
    report();
  end
endmodule